// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is a single channel of a DMA engine. Software programs a small window of word registers: source address, destination address, byte count, three words for two-dimensional transfers (stored but unused), a next-descriptor pointer and a control word. When software sets the enable bit, the channel copies data one beat at a time over a simple memory master port. Each beat is a read from the source followed by a write of the same word to the destination. The channel either runs freely or waits for a peripheral request line before each beat.

When the byte count of a segment reaches zero, the channel looks at the next-descriptor pointer. A zero pointer ends the transfer. A nonzero pointer makes the channel read a nine-word descriptor from memory. That descriptor has the same word layout as the register window, so each word loads straight into the register of the same index, and the transfer then continues. A descriptor that points back to itself, or to an earlier descriptor, forms an endless ring.

Software can read the pointer register while a chain runs to see how far the chain has progressed. The control word also lets software pause, resume and abort the channel. The channel reports segment completion and bus faults as single-cycle pulses.

Top module: `dma_ll_channel`

## Requirements
- R1: The register window is addressed by word index. Index 0 is the source, 1 the destination, 2 the byte count, 3 to 5 the two-dimensional words, 7 the next pointer and 8 the control word. Index 6 and indices 9 to 15 always read zero and ignore writes. All registers reset to zero and busy is low after reset.
- R2: While the channel is idle, writing the control word with bit 0 (enable) set and bit 31 (force close) clear raises busy on the next clock. Each beat then reads the source address and writes the returned word to the destination address.
- R3: Control bits 8:6 hold the source width code and bits 15:13 the destination width code. Codes 0, 1 and 2 mean 1, 2 and 4 bytes; any higher code is limited to 4 bytes. After each beat, a memory side advances its address by its beat bytes. A side whose fixed-address bit is set keeps its address (bit 2 for the source, bit 3 for the destination).
- R4: Each beat reduces the byte count by min(source width bytes, remaining count), so a short last beat takes only the remaining bytes. A segment ends when the count is zero.
- R5: At the end of a segment with a nonzero pointer P, the channel reads the nine words at P, P+4, ..., P+0x20 in that order and loads each into the register of the same index. Word 6 is discarded. The channel then continues with the loaded segment.
- R6: At the end of a segment whose pointer is zero, busy falls and the channel clears enable bit 0 of the control word.
- R7: A descriptor whose pointer refers back to itself repeats without end, and busy stays high.
- R8: At every segment end where control bits 5:4 are not both zero, tc_pulse is high for exactly one cycle. Segments with both bits zero give no pulse.
- R9: Writing the control word with bit 0 clear and bit 31 clear stops new beats once the current bus transaction finishes; busy stays high. Setting bit 0 again resumes the transfer without losing or repeating data.
- R10: Writing the control word with bit 31 set and bit 0 clear aborts the channel at the next beat or descriptor-word boundary. Busy falls and no further bus requests are issued.
- R11: A mem_err response on a descriptor read or a source read gives one src_err pulse. On a destination write it gives one dst_err pulse. In either case the channel stops, busy falls and enable bit 0 is cleared.
- R12: With control bit 1 (software request) clear, each beat waits until dma_req is high. With bit 1 set, beats start without waiting.
- R13: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_wdata held steady until a cycle in which mem_ready or mem_err is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_word | input | 4 | Register word index (byte offset divided by 4) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_word |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Transaction completes this cycle |
| mem_err | input | 1 | Transaction fails this cycle |
| dma_req | input | 1 | Peripheral request that paces beats |
| busy | output | 1 | Channel active |
| tc_pulse | output | 1 | Segment-complete event |
| src_err | output | 1 | Source-side or descriptor fault event |
| dst_err | output | 1 | Destination-side fault event |

## Verification
The bench targets the short last beat. A design that decrements by the full width would underflow the count and run far past the end of the buffer. It chains into a descriptor whose reserved word holds nonzero data and whose interrupt bits differ from the first segment's. An off-by-one in the fetch index would load fields into the wrong registers, and a missing interrupt gate would give an extra completion pulse. It pauses, paces with the request line and force-closes a ring in mid-flight; an engine that ignored the control word between beats would keep writing or never fall idle. Faults are injected on a source read, a destination write and a descriptor word, and a design that mixed up the sides would pulse the wrong error line.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
  localparam int WIN_WORDS = 9;
  localparam int IDX_W     = 4;
  localparam int SRC_IDX   = 0;
  localparam int DST_IDX   = 1;
  localparam int CNT_IDX   = 2;
  localparam int RSV_IDX   = 6;
  localparam int LLI_IDX   = 7;
  localparam int CTRL_IDX  = 8;

  typedef struct packed {
    logic       force_close;
    logic [2:0] dst_wcode;
    logic [2:0] src_wcode;
    logic [1:0] irq_en;
    logic       dst_fixed;
    logic       src_fixed;
    logic       soft_go;
    logic       enable;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEG, ST_RD, ST_WR, ST_FETCH
  } st_e;
endpackage

// File: rtl/dmach_regs.sv
`timescale 1ns/1ps
module dmach_regs
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [31:0]      ld_data,
  input  logic             adv,
  input  logic [31:0]      src_inc,
  input  logic [31:0]      dst_inc,
  input  logic [31:0]      cnt_dec,
  input  logic             clr_en,
  output logic [31:0]      src,
  output logic [31:0]      dst,
  output logic [31:0]      cnt,
  output logic [31:0]      lli,
  output ctl_t             ctl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_WORDS - 1);

  logic [31:0] r_q [WIN_WORDS];
  logic [31:0] r_d [WIN_WORDS];

  // next state: descriptor load, then host write, then beat advance, then enable clear
  always_comb begin
    for (int i = 0; i < WIN_WORDS; i++) r_d[i] = r_q[i];
    if (ld_we && ld_idx <= LAST_IDX) r_d[ld_idx] = ld_data;
    if (host_we && host_idx <= LAST_IDX) r_d[host_idx] = host_wdata;
    r_d[RSV_IDX] = '0;
    if (adv) begin
      r_d[SRC_IDX] = r_q[SRC_IDX] + src_inc;
      r_d[DST_IDX] = r_q[DST_IDX] + dst_inc;
      r_d[CNT_IDX] = r_q[CNT_IDX] - cnt_dec;
    end
    if (clr_en) r_d[CTRL_IDX][0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_WORDS; i++) r_q[i] <= '0;
    end else begin
      for (int i = 0; i < WIN_WORDS; i++) r_q[i] <= r_d[i];
    end
  end

  assign host_rdata = (host_idx <= LAST_IDX) ? r_q[host_idx] : '0;
  assign src = r_q[SRC_IDX];
  assign dst = r_q[DST_IDX];
  assign cnt = r_q[CNT_IDX];
  assign lli = r_q[LLI_IDX];
  assign ctl = '{force_close: r_q[CTRL_IDX][31],
                 dst_wcode:   r_q[CTRL_IDX][15:13],
                 src_wcode:   r_q[CTRL_IDX][8:6],
                 irq_en:      r_q[CTRL_IDX][5:4],
                 dst_fixed:   r_q[CTRL_IDX][3],
                 src_fixed:   r_q[CTRL_IDX][2],
                 soft_go:     r_q[CTRL_IDX][1],
                 enable:      r_q[CTRL_IDX][0]};

  // R3: a fixed-address destination never moves on a beat
  p_dst_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ctl.dst_fixed && !host_we) |=> (dst == $past(dst)));
endmodule

// File: rtl/dmach_engine.sv
`timescale 1ns/1ps
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int BUS_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      src,
  input  logic [31:0]      dst,
  input  logic [31:0]      cnt,
  input  logic [31:0]      lli,
  input  ctl_t             ctl,
  input  logic             dma_req,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ready,
  input  logic             mem_err,
  output logic             ld_we,
  output logic [IDX_W-1:0] ld_idx,
  output logic [31:0]      ld_data,
  output logic             adv,
  output logic [31:0]      src_inc,
  output logic [31:0]      dst_inc,
  output logic [31:0]      cnt_dec,
  output logic             clr_en,
  output logic             busy,
  output logic             tc_pulse,
  output logic             src_err,
  output logic             dst_err
);
  localparam int MAXC = $clog2(BUS_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_WORDS - 1);

  st_e              st_q, st_d;
  logic [31:0]      buf_q, fbase_q;
  logic [IDX_W-1:0] fidx_q;
  logic             buf_ld, fbase_ld;
  logic [31:0]      sbytes, dbytes, sbeat, dbeat;
  logic             abort;

  function automatic logic [31:0] width_bytes(input logic [2:0] code);
    if (32'(code) >= MAXC) return 32'(BUS_BYTES);
    else return 32'd1 << code;
  endfunction

  assign sbytes = width_bytes(ctl.src_wcode);
  assign dbytes = width_bytes(ctl.dst_wcode);
  assign sbeat  = (cnt < sbytes) ? cnt : sbytes;
  assign dbeat  = (cnt < dbytes) ? cnt : dbytes;
  assign abort  = ctl.force_close & ~ctl.enable;

  assign src_inc = ctl.src_fixed ? '0 : sbeat;
  assign dst_inc = ctl.dst_fixed ? '0 : dbeat;
  assign cnt_dec = sbeat;
  assign ld_idx  = fidx_q;
  assign ld_data = mem_rdata;
  assign busy    = (st_q != ST_IDLE);

  always_comb begin
    st_d     = st_q;
    buf_ld   = 1'b0;
    fbase_ld = 1'b0;
    ld_we    = 1'b0;
    adv      = 1'b0;
    clr_en   = 1'b0;
    tc_pulse = 1'b0;
    src_err  = 1'b0;
    dst_err  = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    case (st_q)
      ST_IDLE: if (ctl.enable && !ctl.force_close) st_d = ST_SEG;
      ST_SEG: begin
        if (abort) st_d = ST_IDLE;
        else if (!ctl.enable) st_d = ST_SEG;
        else if (cnt == '0) begin
          tc_pulse = |ctl.irq_en;
          if (lli == '0) begin
            clr_en = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            fbase_ld = 1'b1;
            st_d     = ST_FETCH;
          end
        end else if (ctl.soft_go || dma_req) st_d = ST_RD;
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = src;
        if (mem_err) begin
          src_err = 1'b1;
          clr_en  = 1'b1;
          st_d    = ST_IDLE;
        end else if (mem_ready) begin
          buf_ld = 1'b1;
          st_d   = ST_WR;
        end
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst;
        if (mem_err) begin
          dst_err = 1'b1;
          clr_en  = 1'b1;
          st_d    = ST_IDLE;
        end else if (mem_ready) begin
          adv  = 1'b1;
          st_d = ST_SEG;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = fbase_q + {26'd0, fidx_q, 2'b00};
        if (mem_err) begin
          src_err = 1'b1;
          clr_en  = 1'b1;
          st_d    = ST_IDLE;
        end else if (mem_ready) begin
          if (abort) st_d = ST_IDLE;
          else begin
            ld_we = 1'b1;
            if (fidx_q == LAST_IDX) st_d = ST_SEG;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign mem_wdata = buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      buf_q   <= '0;
      fbase_q <= '0;
      fidx_q  <= '0;
    end else begin
      st_q <= st_d;
      if (buf_ld) buf_q <= mem_rdata;
      if (fbase_ld) begin
        fbase_q <= lli;
        fidx_q  <= '0;
      end else if (ld_we) begin
        fidx_q  <= fidx_q + 1'b1;
      end
    end
  end

  // R13: request and its attributes are held until the memory answers
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R8: completion event lasts one cycle
  p_tc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);
  // R11: a fault stops the channel and is reported on one side only
  p_err_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_err || dst_err) |=> !busy);
  p_err_side_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_err && dst_err));
  // R9: a paused channel at a beat boundary issues nothing
  p_pause_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEG && !ctl.enable) |=> !mem_req);
endmodule

// File: rtl/dma_ll_channel.sv
`timescale 1ns/1ps
module dma_ll_channel
  import dmach_pkg::*;
#(
  parameter int BUS_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_word,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  input  logic        mem_err,
  input  logic        dma_req,
  output logic        busy,
  output logic        tc_pulse,
  output logic        src_err,
  output logic        dst_err
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic             ld_we, adv, clr_en;
  logic [IDX_W-1:0] ld_idx;
  logic [31:0]      ld_data, src_inc, dst_inc, cnt_dec;
  logic [31:0]      src, dst, cnt, lli;
  ctl_t             ctl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  dmach_regs u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .host_we(cfg_we), .host_idx(cfg_word), .host_wdata(cfg_wdata), .host_rdata(cfg_rdata),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .adv(adv), .src_inc(src_inc), .dst_inc(dst_inc), .cnt_dec(cnt_dec), .clr_en(clr_en),
    .src(src), .dst(dst), .cnt(cnt), .lli(lli), .ctl(ctl)
  );

  dmach_engine #(.BUS_BYTES(BUS_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n_i),
    .src(src), .dst(dst), .cnt(cnt), .lli(lli), .ctl(ctl), .dma_req(dma_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .adv(adv), .src_inc(src_inc), .dst_inc(dst_inc), .cnt_dec(cnt_dec), .clr_en(clr_en),
    .busy(busy), .tc_pulse(tc_pulse), .src_err(src_err), .dst_err(dst_err)
  );

  // R6: once idle, the channel keeps the bus quiet until re-enabled
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!busy && !$past(busy) && !ctl.enable) |-> !mem_req);
endmodule

// File: tb/dma_ll_channel_test.sv
`timescale 1ns/1ps
module dma_ll_channel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_word;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready, mem_err, dma_req;
  logic        busy, tc_pulse, src_err, dst_err;

  int n_chk = 0, n_fail = 0;
  int lat_cfg = 1, lat_cnt;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] mem [256];
  logic [31:0] wlog [64];
  int wr_n = 0, tc_n = 0, serr_n = 0, derr_n = 0, proto_bad = 0;
  logic prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  localparam logic [31:0] EN = 32'h1, SOFT = 32'h2, SFIX = 32'h4, DFIX = 32'h8;
  localparam logic [31:0] IRQ = 32'h30, FORCE = 32'h8000_0000;
  localparam logic [31:0] W2 = (32'd2 << 6) | (32'd2 << 13);

  always #10 clk = ~clk;

  dma_ll_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .dma_req(dma_req), .busy(busy),
    .tc_pulse(tc_pulse), .src_err(src_err), .dst_err(dst_err)
  );

  // memory model with programmable latency and fault injection
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_err <= 1'b0; lat_cnt <= 0; mem_rdata <= '0;
    end else if (mem_ready || mem_err) begin
      mem_ready <= 1'b0; mem_err <= 1'b0; lat_cnt <= 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat_cfg) begin
        if (err_en && mem_addr == err_addr) mem_err <= 1'b1;
        else begin
          mem_ready <= 1'b1;
          if (mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wlog[wr_n[5:0]] <= mem_addr;
            wr_n <= wr_n + 1;
          end else mem_rdata <= mem[mem_addr[9:2]];
        end
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (tc_pulse) tc_n = tc_n + 1;
    if (src_err) serr_n = serr_n + 1;
    if (dst_err) derr_n = derr_n + 1;
    if (prev_pend && (!mem_req || mem_addr != prev_addr)) proto_bad = proto_bad + 1;
    prev_pend = mem_req && !mem_ready && !mem_err;
    prev_addr = mem_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_word = w; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] w, output logic [31:0] d);
    @(negedge clk); cfg_word = w; #1 d = cfg_rdata;
  endtask

  task automatic prog(input logic [31:0] s, dd, c, l, ctrl);
    reg_wr(4'd0, s); reg_wr(4'd1, dd); reg_wr(4'd2, c); reg_wr(4'd7, l); reg_wr(4'd8, ctrl);
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    reg_rd(4'd8, v); chk("R1 control reset", v, 32'd0);
    reg_rd(4'd0, v); chk("R1 source reset", v, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) reg_wr(4'(i), 32'h1100_0000 + 32'(i));
    reg_wr(4'd8, 32'h0000_2440);
    reg_wr(4'd12, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) begin
      reg_rd(4'(i), v); chk("R1 readback", v, 32'h1100_0000 + 32'(i));
    end
    reg_rd(4'd6, v); chk("R1 reserved word reads zero", v, 32'd0);
    reg_rd(4'd7, v); chk("R1 pointer readback", v, 32'h1100_0007);
    reg_rd(4'd8, v); chk("R1 control readback", v, 32'h0000_2440);
    reg_rd(4'd12, v); chk("R1 out-of-window reads zero", v, 32'd0);
    reg_wr(4'd3, 0); reg_wr(4'd4, 0); reg_wr(4'd5, 0);
  endtask

  task automatic t_single;
    logic [31:0] v; int tc0;
    for (int i = 0; i < 3; i++) mem[8'h40 + i] = 32'hA000 + 32'(i);
    tc0 = tc_n;
    prog(32'h100, 32'h200, 12, 0, EN | SOFT | IRQ | W2);
    @(negedge clk); chk("R2 busy after enable", {31'd0, busy}, 32'd1);
    wait_idle(500);
    for (int i = 0; i < 3; i++) chk("R2 copied word", mem[8'h80 + i], 32'hA000 + 32'(i));
    reg_rd(4'd0, v); chk("R3 source advanced", v, 32'h10C);
    reg_rd(4'd1, v); chk("R3 destination advanced", v, 32'h20C);
    reg_rd(4'd2, v); chk("R4 count zero", v, 32'd0);
    reg_rd(4'd8, v); chk("R6 enable cleared", v & EN, 32'd0);
    chk("R6 busy low", {31'd0, busy}, 32'd0);
    chk("R8 one completion pulse", 32'(tc_n - tc0), 32'd1);
  endtask

  task automatic t_partial;
    logic [31:0] v; int w0;
    w0 = wr_n;
    prog(32'h100, 32'h200, 6, 0, EN | SOFT | W2);
    wait_idle(500);
    chk("R4 short last beat gives two writes", 32'(wr_n - w0), 32'd2);
    reg_rd(4'd0, v); chk("R4 source moved by bytes moved", v, 32'h106);
    reg_rd(4'd2, v); chk("R4 count zero after short beat", v, 32'd0);
  endtask

  task automatic t_width;
    logic [31:0] v; int w0, bad;
    w0 = wr_n; bad = 0;
    prog(32'h100, 32'h2F0, 3, 0, EN | SOFT | DFIX | (32'd2 << 13));
    wait_idle(500);
    chk("R3 byte beats", 32'(wr_n - w0), 32'd3);
    for (int i = w0; i < wr_n; i++) if (wlog[i[5:0]] != 32'h2F0) bad++;
    chk("R3 fixed destination address", 32'(bad), 32'd0);
    reg_rd(4'd0, v); chk("R3 byte source step", v, 32'h103);
    reg_rd(4'd1, v); chk("R3 fixed destination register", v, 32'h2F0);
    w0 = wr_n;
    prog(32'h100, 32'h200, 8, 0, EN | SOFT | (32'd3 << 6) | (32'd3 << 13));
    wait_idle(500);
    chk("R3 width code 3 limited to 4 bytes", 32'(wr_n - w0), 32'd2);
    reg_rd(4'd0, v); chk("R3 clamped source step", v, 32'h108);
  endtask

  task automatic t_chain;
    logic [31:0] v; int tc0;
    mem[8'hC0] = 32'h140; mem[8'hC1] = 32'h240; mem[8'hC2] = 8;
    mem[8'hC3] = 0; mem[8'hC4] = 0; mem[8'hC5] = 0; mem[8'hC6] = 32'h5555;
    mem[8'hC7] = 0; mem[8'hC8] = EN | SOFT | IRQ | W2;
    mem[8'h50] = 32'hB0; mem[8'h51] = 32'hB1;
    tc0 = tc_n;
    prog(32'h100, 32'h200, 4, 32'h300, EN | SOFT | W2);
    wait_idle(1000);
    chk("R5 chained word 0", mem[8'h90], 32'hB0);
    chk("R5 chained word 1", mem[8'h91], 32'hB1);
    reg_rd(4'd0, v); chk("R5 source loaded and advanced", v, 32'h148);
    reg_rd(4'd7, v); chk("R5 pointer loaded", v, 32'd0);
    reg_rd(4'd6, v); chk("R5 reserved word discarded", v, 32'd0);
    chk("R8 pulse only for enabled segment", 32'(tc_n - tc0), 32'd1);
  endtask

  task automatic t_ring;
    logic [31:0] v; int tc0, w0;
    mem[8'hE0] = 32'h160; mem[8'hE1] = 32'h260; mem[8'hE2] = 4;
    for (int i = 3; i < 7; i++) mem[8'hE0 + i] = 0;
    mem[8'hE7] = 32'h380; mem[8'hE8] = EN | SOFT | IRQ | W2;
    mem[8'h58] = 32'hC0;
    tc0 = tc_n;
    prog(0, 0, 0, 32'h380, EN | SOFT | W2);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (tc_n - tc0 >= 3) break;
    end
    chk("R7 ring repeats", {31'd0, (tc_n - tc0) >= 3}, 32'd1);
    chk("R7 busy during ring", {31'd0, busy}, 32'd1);
    reg_rd(4'd7, v); chk("R7 pointer loops to itself", v, 32'h380);
    chk("R7 ring data", mem[8'h98], 32'hC0);
    reg_wr(4'd8, FORCE);
    idle_cycles(30);
    chk("R10 busy low after force close", {31'd0, busy}, 32'd0);
    w0 = wr_n;
    idle_cycles(20);
    chk("R10 no writes after force close", 32'(wr_n - w0), 32'd0);
    chk("R10 no request after force close", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_pause;
    int w0, snap, bad;
    for (int i = 0; i < 16; i++) begin
      mem[8'h40 + i] = 32'hD000 + 32'(i); mem[8'h80 + i] = 0;
    end
    lat_cfg = 3; w0 = wr_n; bad = 0;
    prog(32'h100, 32'h200, 64, 0, EN | SOFT | W2);
    idle_cycles(20);
    reg_wr(4'd8, SOFT | W2);
    idle_cycles(10);
    snap = wr_n;
    idle_cycles(30);
    chk("R9 no writes while paused", 32'(wr_n - snap), 32'd0);
    chk("R9 busy while paused", {31'd0, busy}, 32'd1);
    chk("R9 paused before end", {31'd0, (snap - w0) < 16}, 32'd1);
    reg_wr(4'd8, EN | SOFT | W2);
    wait_idle(2000);
    for (int i = 0; i < 16; i++) if (mem[8'h80 + i] != 32'hD000 + 32'(i)) bad++;
    chk("R9 all words after resume", 32'(bad), 32'd0);
    chk("R9 no repeated beats", 32'(wr_n - w0), 32'd16);
    lat_cfg = 1;
  endtask

  task automatic t_pacing;
    int w0;
    w0 = wr_n; dma_req = 1'b0;
    prog(32'h100, 32'h220, 8, 0, EN | W2);
    idle_cycles(20);
    chk("R12 no beat without request", 32'(wr_n - w0), 32'd0);
    chk("R12 busy while waiting", {31'd0, busy}, 32'd1);
    dma_req = 1'b1;
    wait_idle(500);
    chk("R12 beats after request", 32'(wr_n - w0), 32'd2);
    dma_req = 1'b0;
  endtask

  task automatic t_faults;
    logic [31:0] v; int s0, d0, w0;
    s0 = serr_n; d0 = derr_n; w0 = wr_n;
    err_en = 1'b1; err_addr = 32'h104;
    prog(32'h100, 32'h200, 12, 0, EN | SOFT | W2);
    wait_idle(500);
    chk("R11 source fault pulse", 32'(serr_n - s0), 32'd1);
    chk("R11 no destination pulse", 32'(derr_n - d0), 32'd0);
    chk("R11 one beat before fault", 32'(wr_n - w0), 32'd1);
    reg_rd(4'd8, v); chk("R11 enable cleared", v & EN, 32'd0);
    s0 = serr_n; d0 = derr_n; err_addr = 32'h204;
    prog(32'h100, 32'h200, 12, 0, EN | SOFT | W2);
    wait_idle(500);
    chk("R11 destination fault pulse", 32'(derr_n - d0), 32'd1);
    chk("R11 no source pulse", 32'(serr_n - s0), 32'd0);
    s0 = serr_n; err_addr = 32'h308;
    prog(32'h100, 32'h200, 4, 32'h300, EN | SOFT | W2);
    wait_idle(500);
    chk("R11 descriptor fault pulse", 32'(serr_n - s0), 32'd1);
    chk("R11 busy low after fault", {31'd0, busy}, 32'd0);
    err_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0; cfg_wdata = '0; dma_req = 1'b0;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(4);
    t_reset();
    t_regs();
    t_single();
    t_partial();
    t_width();
    t_chain();
    t_ring();
    t_pause();
    t_pacing();
    t_faults();
    chk("R13 request held until answered", 32'(proto_bad), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule